// File: doc/BRIEF.md
# Configuration Space Enumeration Engine

This block runs on the controller side of a configuration bus. After reset it waits for a start pulse. It then walks every bus number and, within each bus, every device number, always at function 0. For each slot it issues one configuration read of the identifier word. A slot that does not answer, or that reports the all-ones vendor code, is passed over at once. For a slot that answers, the engine sizes its first base-address register in three steps: it writes all ones, reads the register back, and takes the two's complement of the masked readback. It then takes an aligned window from a running address allocator and writes the chosen base back into the same register.

Every device found is entered in a small discovery table. Each entry holds the bus, device, vendor identifier, device identifier and assigned base. The table can be read through an index port. A one-cycle done pulse marks the end of the walk. Requests leave on a single-outstanding request/response port. Each request carries a 16-bit locator and an 8-bit register offset, and stays on the port until a response arrives.

Top module: `cfg_enum_engine`

## Requirements
- R1: After reset the engine is idle: `req_valid` is low, `done` is low and `tbl_count` is 0.
- R2: The locator is packed as bus in bits 15:8, device in bits 7:3 and function in bits 2:0, and the function bits are always 0. Slots are visited once each, in ascending order: device runs from 0 to DEV_PER_BUS-1 inside a bus, and bus runs from 0 to BUS_COUNT-1. The first request to every slot is a read (`req_write`=0) at offset 0x00.
- R3: Only one request is outstanding at a time. While `rsp_valid` is low, `req_valid`, `req_write`, `req_loc`, `req_off` and `req_wdata` hold their values.
- R4: A slot counts as empty when the identifier read returns `rsp_nodev`=1, or returns 16'hFFFF in `rsp_data[15:0]`. After an empty slot the next request is the identifier read of the following slot, and the empty slot gets no write and no table entry.
- R5: A slot that answers is sized as follows. The engine writes 32'hFFFF_FFFF to offset 0x10, then reads offset 0x10. The window size is the two's complement of the readback with bits 3:0 cleared.
- R6: Each window base is the allocator's next free address rounded up to a multiple of the window size. The next free address then becomes base plus size. On each start the allocator restarts at BASE_ADDR.
- R7: The assigned base is written to offset 0x10 of the same locator, once per answering slot.
- R8: The table records answering slots in discovery order. Each entry holds bus, device, vendor (`rsp_data[15:0]` of the identifier read), device identifier (`rsp_data[31:16]`) and base. `tbl_count` saturates at TABLE_DEPTH. Answering slots found after the table is full are still sized and programmed.
- R9: `done` is high for exactly one cycle after the response for the last slot. No request follows it.
- R10: A start pulse during a scan is ignored, and the scan's results are unchanged.
- R11: A new start clears the table count and the allocator before the walk begins again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a scan when idle |
| req_valid | output | 1 | Request present |
| req_write | output | 1 | 1 = configuration write, 0 = read |
| req_loc | output | 16 | Bus/device/function locator |
| req_off | output | 8 | Register offset |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Response for the pending request |
| rsp_data | input | 32 | Read data |
| rsp_nodev | input | 1 | No device answered |
| done | output | 1 | One-cycle scan completion pulse |
| tbl_idx | input | $clog2(TABLE_DEPTH) | Table read index |
| tbl_count | output | $clog2(TABLE_DEPTH+1) | Entries recorded |
| tbl_bus | output | 8 | Entry bus number |
| tbl_dev | output | 5 | Entry device number |
| tbl_vid | output | 16 | Entry vendor identifier |
| tbl_did | output | 16 | Entry device identifier |
| tbl_base | output | 32 | Entry assigned base |

## Verification
The bench builds the engine with BUS_COUNT=3, DEV_PER_BUS=4, TABLE_DEPTH=4 and BASE_ADDR=32'h4000_0000. With these values the whole walk is twelve slots. The device-number wrap into a new bus happens twice per scan. A scan with six answering devices overflows the four-entry table. Window sizes from 16 bytes to 1 MiB force both aligned and unaligned starting points for the allocator. Response latency is varied, so requests must be held across several wait cycles.

// File: rtl/cfg_enum_pkg.sv
package cfg_enum_pkg;

  localparam logic [7:0] OFF_IDENT = 8'h00;
  localparam logic [7:0] OFF_WIN   = 8'h10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_IDENT, ST_ONES, ST_SIZE, ST_PROG, ST_NEXT, ST_DONE
  } enum_state_t;

  typedef struct packed {
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [15:0] vid;
    logic [15:0] did;
    logic [31:0] base;
  } disc_entry_t;

  function automatic logic [15:0] pack_loc(input logic [7:0] bus,
                                           input logic [4:0] dev,
                                           input logic [2:0] fn);
    return {bus, dev, fn};
  endfunction

  // two's complement of the readback with the attribute bits masked
  function automatic logic [31:0] win_size(input logic [31:0] readback);
    return (~(readback & 32'hFFFF_FFF0)) + 32'd1;
  endfunction

  // round addr up to a multiple of a power-of-two size
  function automatic logic [31:0] round_up(input logic [31:0] addr,
                                           input logic [31:0] size);
    return (addr + size - 32'd1) & ~(size - 32'd1);
  endfunction

endpackage

// File: rtl/cfg_slot_walker.sv
module cfg_slot_walker #(
  parameter int BUS_COUNT   = 2,
  parameter int DEV_PER_BUS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       step,
  output logic [7:0] bus,
  output logic [4:0] dev,
  output logic       last
);
  localparam logic [7:0] BUS_LAST = 8'(BUS_COUNT - 1);
  localparam logic [4:0] DEV_LAST = 5'(DEV_PER_BUS - 1);

  logic [7:0] bus_q;
  logic [4:0] dev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q <= '0;
      dev_q <= '0;
    end else if (clear) begin
      bus_q <= '0;
      dev_q <= '0;
    end else if (step) begin
      if (dev_q == DEV_LAST) begin
        dev_q <= '0;
        bus_q <= bus_q + 8'd1;
      end else begin
        dev_q <= dev_q + 5'd1;
      end
    end
  end

  assign bus  = bus_q;
  assign dev  = dev_q;
  assign last = (bus_q == BUS_LAST) && (dev_q == DEV_LAST);

  // R2: walk never leaves the configured slot range
  assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_q <= DEV_LAST) && (bus_q <= BUS_LAST));

endmodule

// File: rtl/cfg_window_alloc.sv
module cfg_window_alloc
  import cfg_enum_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h8000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        grant,
  input  logic [31:0] size,
  output logic [31:0] base
);
  logic [31:0] next_q;

  assign base = round_up(next_q, size);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     next_q <= BASE_ADDR;
    else if (clear) next_q <= BASE_ADDR;
    else if (grant) next_q <= base + size;
  end

  // R6: a granted window is aligned to its size and never below the free mark
  assert_base_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (((base & (size - 32'd1)) == 32'd0) && (base >= next_q)));

endmodule

// File: rtl/cfg_disc_table.sv
module cfg_disc_table
  import cfg_enum_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr_en,
  input  disc_entry_t   wr_entry,
  input  logic [IW-1:0] rd_idx,
  output disc_entry_t   rd_entry,
  output logic [CW-1:0] count
);
  disc_entry_t   mem_q [DEPTH];
  logic [CW-1:0] count_q;
  logic          full;

  assign full = (count_q == CW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               count_q <= '0;
    else if (clear)           count_q <= '0;
    else if (wr_en && !full)  count_q <= count_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (wr_en && !full && !clear) mem_q[count_q[IW-1:0]] <= wr_entry;
  end

  assign rd_entry = (32'(rd_idx) < DEPTH) ? mem_q[rd_idx] : '0;
  assign count    = count_q;

  // R8: count saturates at the table depth
  assert_count_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));

  // R8: count moves only on a recorded write or a clear
  assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !wr_en) |=> $stable(count_q));

endmodule

// File: rtl/cfg_enum_engine.sv
module cfg_enum_engine
  import cfg_enum_pkg::*;
#(
  parameter int          BUS_COUNT   = 2,
  parameter int          DEV_PER_BUS = 32,
  parameter int          TABLE_DEPTH = 4,
  parameter logic [31:0] BASE_ADDR   = 32'h8000_0000
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  output logic                             req_valid,
  output logic                             req_write,
  output logic [15:0]                      req_loc,
  output logic [7:0]                       req_off,
  output logic [31:0]                      req_wdata,
  input  logic                             rsp_valid,
  input  logic [31:0]                      rsp_data,
  input  logic                             rsp_nodev,
  output logic                             done,
  input  logic [$clog2(TABLE_DEPTH)-1:0]   tbl_idx,
  output logic [$clog2(TABLE_DEPTH+1)-1:0] tbl_count,
  output logic [7:0]                       tbl_bus,
  output logic [4:0]                       tbl_dev,
  output logic [15:0]                      tbl_vid,
  output logic [15:0]                      tbl_did,
  output logic [31:0]                      tbl_base
);
  enum_state_t state_q;
  logic [15:0] vid_q, did_q;
  logic [31:0] size_q;

  logic [7:0]  cur_bus;
  logic [4:0]  cur_dev;
  logic        cur_last;
  logic [31:0] win_base;
  disc_entry_t rd_entry;

  // named events
  logic scan_begin, rsp_take, slot_empty, win_grant, slot_step;

  assign scan_begin = (state_q == ST_IDLE) && start;
  assign rsp_take   = req_valid && rsp_valid;
  assign slot_empty = rsp_take && (state_q == ST_IDENT) &&
                      (rsp_nodev || (rsp_data[15:0] == 16'hFFFF));
  assign win_grant  = rsp_take && (state_q == ST_PROG);
  assign slot_step  = (state_q == ST_NEXT) && !cur_last;

  cfg_slot_walker #(.BUS_COUNT(BUS_COUNT), .DEV_PER_BUS(DEV_PER_BUS)) u_walk (
    .clk(clk), .rst_n(rst_n), .clear(scan_begin), .step(slot_step),
    .bus(cur_bus), .dev(cur_dev), .last(cur_last));

  cfg_window_alloc #(.BASE_ADDR(BASE_ADDR)) u_alloc (
    .clk(clk), .rst_n(rst_n), .clear(scan_begin), .grant(win_grant),
    .size(size_q), .base(win_base));

  cfg_disc_table #(.DEPTH(TABLE_DEPTH)) u_tab (
    .clk(clk), .rst_n(rst_n), .clear(scan_begin), .wr_en(win_grant),
    .wr_entry('{bus: cur_bus, dev: cur_dev, vid: vid_q, did: did_q, base: win_base}),
    .rd_idx(tbl_idx), .rd_entry(rd_entry), .count(tbl_count));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vid_q   <= '0;
      did_q   <= '0;
      size_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (start) state_q <= ST_IDENT;
        ST_IDENT: if (rsp_take) begin
          if (slot_empty) state_q <= ST_NEXT;
          else begin
            vid_q   <= rsp_data[15:0];
            did_q   <= rsp_data[31:16];
            state_q <= ST_ONES;
          end
        end
        ST_ONES:  if (rsp_take) state_q <= ST_SIZE;
        ST_SIZE:  if (rsp_take) begin
          size_q  <= win_size(rsp_data);
          state_q <= ST_PROG;
        end
        ST_PROG:  if (rsp_take) state_q <= ST_NEXT;
        ST_NEXT:  state_q <= cur_last ? ST_DONE : ST_IDENT;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_valid = (state_q == ST_IDENT) || (state_q == ST_ONES) ||
                (state_q == ST_SIZE)  || (state_q == ST_PROG);
    req_write = (state_q == ST_ONES) || (state_q == ST_PROG);
    req_off   = (state_q == ST_IDENT) ? OFF_IDENT : OFF_WIN;
    req_loc   = pack_loc(cur_bus, cur_dev, 3'd0);
    if (state_q == ST_ONES)      req_wdata = 32'hFFFF_FFFF;
    else if (state_q == ST_PROG) req_wdata = win_base;
    else                         req_wdata = 32'd0;
  end

  assign done     = (state_q == ST_DONE);
  assign tbl_bus  = rd_entry.bus;
  assign tbl_dev  = rd_entry.dev;
  assign tbl_vid  = rd_entry.vid;
  assign tbl_did  = rd_entry.did;
  assign tbl_base = rd_entry.base;

  // R3: an unanswered request is held unchanged
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_valid) |=> (req_valid && $stable(req_loc) &&
      $stable(req_off) && $stable(req_write) && $stable(req_wdata)));

  // R4: an empty slot gets no further request in the following cycle
  assert_empty_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_empty |=> !req_valid);

  // R9: done is a single-cycle pulse with no request after it
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !req_valid));

  // R10: start while busy does not restart the walk
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (state_q == ST_SIZE)) |=> (state_q != ST_IDENT));

endmodule

// File: tb/sim_cfg_enum_engine.sv
`timescale 1ns/1ps
module sim_cfg_enum_engine;
  localparam int BUSES = 3;
  localparam int DEVS  = 4;
  localparam int DEPTH = 4;
  localparam int NSLOT = BUSES * DEVS;
  localparam logic [31:0] BASE = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        req_valid, req_write;
  logic [15:0] req_loc;
  logic [7:0]  req_off;
  logic [31:0] req_wdata;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        rsp_nodev = 1'b0;
  logic        done;
  logic [1:0]  tbl_idx = '0;
  logic [2:0]  tbl_count;
  logic [7:0]  tbl_bus;
  logic [4:0]  tbl_dev;
  logic [15:0] tbl_vid, tbl_did;
  logic [31:0] tbl_base;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cfg_enum_engine #(.BUS_COUNT(BUSES), .DEV_PER_BUS(DEVS), .TABLE_DEPTH(DEPTH),
                    .BASE_ADDR(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_valid(req_valid), .req_write(req_write), .req_loc(req_loc),
    .req_off(req_off), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_nodev(rsp_nodev),
    .done(done), .tbl_idx(tbl_idx), .tbl_count(tbl_count),
    .tbl_bus(tbl_bus), .tbl_dev(tbl_dev), .tbl_vid(tbl_vid),
    .tbl_did(tbl_did), .tbl_base(tbl_base));

  // device population model
  logic        pres   [NSLOT];
  logic        allone [NSLOT];
  logic [15:0] vid_m  [NSLOT];
  logic [15:0] did_m  [NSLOT];
  logic [31:0] size_m [NSLOT];
  logic [31:0] bar_m  [NSLOT];
  logic [31:0] wbase  [NSLOT];
  int          nwr    [NSLOT];
  int          exp_slot = 0;
  int          rsp_lat = 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_devs();
    for (int s = 0; s < NSLOT; s++) begin
      pres[s] = 0; allone[s] = 0; vid_m[s] = '0; did_m[s] = '0;
      size_m[s] = 32'h10; bar_m[s] = '0; wbase[s] = '0; nwr[s] = 0;
    end
  endtask

  task automatic add_dev(input int s, input logic [15:0] v, input logic [15:0] d,
                         input logic [31:0] sz);
    pres[s] = 1; vid_m[s] = v; did_m[s] = d; size_m[s] = sz;
  endtask

  // responder: answers each request after rsp_lat cycles
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && req_valid) begin
        automatic logic [15:0] loc = req_loc;
        automatic logic [7:0]  off = req_off;
        automatic logic        wr  = req_write;
        automatic logic [31:0] wd  = req_wdata;
        automatic int          s   = int'(loc[15:8]) * DEVS + int'(loc[7:3]);
        automatic logic [15:0] exl = {8'(exp_slot / DEVS), 5'(exp_slot % DEVS), 3'd0};
        if (s >= NSLOT) s = 0;
        if (!wr && off == 8'h00) begin
          chk(loc == exl, "R2 slot order/locator", {16'd0, loc}, {16'd0, exl});
          exp_slot++;
        end else begin
          chk(pres[s] && !allone[s], "R4 request to empty slot", {16'd0, loc}, 32'd0);
        end
        for (int k = 1; k < rsp_lat; k++) begin
          @(negedge clk);
          chk(req_valid && req_loc == loc && req_off == off && req_write == wr &&
              req_wdata == wd, "R3 request hold", {16'd0, req_loc}, {16'd0, loc});
        end
        rsp_nodev = 1'b0;
        rsp_data  = '0;
        if (!wr && off == 8'h00) begin
          if (!pres[s])       rsp_nodev = 1'b1;
          else if (allone[s]) rsp_data  = 32'hFFFF_FFFF;
          else                rsp_data  = {did_m[s], vid_m[s]};
        end else if (!wr && off == 8'h10) begin
          rsp_data = bar_m[s] | 32'h8;
        end else if (wr && off == 8'h10) begin
          if (wd == 32'hFFFF_FFFF) bar_m[s] = ~(size_m[s] - 32'd1);
          else begin
            wbase[s] = wd;
            nwr[s]++;
            bar_m[s] = wd & ~(size_m[s] - 32'd1);
          end
        end
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_nodev = 1'b0;
      end
    end
  end

  task automatic run_scan(input bit mid_start);
    int guard;
    exp_slot = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (mid_start) begin
      repeat (25) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    chk(done == 1'b1, "R9 done seen", {31'd0, done}, 32'd1);
    @(negedge clk);
    chk(!done && !req_valid, "R9 done single pulse", {30'd0, done, req_valid}, 32'd0);
    chk(exp_slot == NSLOT, "R2 every slot probed once", exp_slot, NSLOT);
  endtask

  task automatic verify_results();
    logic [31:0] nf = BASE;
    int idx = 0;
    for (int s = 0; s < NSLOT; s++) begin
      if (pres[s] && !allone[s]) begin
        automatic logic [31:0] sz = size_m[s];
        automatic logic [31:0] b  = ((nf + sz - 32'd1) / sz) * sz;
        nf = b + sz;
        chk(nwr[s] == 1, "R7 one base write", nwr[s], 1);
        chk(wbase[s] == b, "R5 R6 window base", wbase[s], b);
        if (idx < DEPTH) begin
          tbl_idx = 2'(idx);
          #1;
          chk(tbl_bus == 8'(s / DEVS) && tbl_dev == 5'(s % DEVS), "R8 entry bus/dev",
              {19'd0, tbl_bus, tbl_dev}, {19'd0, 8'(s / DEVS), 5'(s % DEVS)});
          chk(tbl_vid == vid_m[s] && tbl_did == did_m[s], "R8 entry ids",
              {tbl_did, tbl_vid}, {did_m[s], vid_m[s]});
          chk(tbl_base == b, "R8 entry base", tbl_base, b);
        end
        idx++;
      end else begin
        chk(nwr[s] == 0, "R4 empty slot untouched", nwr[s], 0);
      end
    end
    chk(int'(tbl_count) == ((idx < DEPTH) ? idx : DEPTH), "R8 R11 table count",
        {29'd0, tbl_count}, (idx < DEPTH) ? idx : DEPTH);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!req_valid && !done && tbl_count == 0, "R1 reset state",
        {29'd0, req_valid, done, 1'b0} | {29'd0, tbl_count}, 32'd0);
  endtask

  task automatic t_mixed();
    clear_devs();
    add_dev(0, 16'h1234, 16'h0001, 32'h1000);
    allone[2] = 1; pres[2] = 1;
    add_dev(3, 16'h5678, 16'h0002, 32'h10);
    add_dev(5, 16'h9ABC, 16'h0003, 32'h0010_0000);
    add_dev(11, 16'hDEF0, 16'h0004, 32'h100);
    rsp_lat = 1;
    run_scan(1'b0);
    verify_results();
  endtask

  task automatic t_overflow();
    clear_devs();
    add_dev(1, 16'h1111, 16'hA001, 32'h100);
    add_dev(2, 16'h2222, 16'hA002, 32'h20);
    add_dev(4, 16'h3333, 16'hA003, 32'h4000);
    add_dev(6, 16'h4444, 16'hA004, 32'h10);
    add_dev(7, 16'h5555, 16'hA005, 32'h800);
    add_dev(9, 16'h6666, 16'hA006, 32'h40);
    rsp_lat = 3;
    run_scan(1'b1); // R10: start pulse in the middle is ignored
    verify_results();
  endtask

  task automatic t_empty();
    clear_devs();
    allone[4] = 1; pres[4] = 1;
    rsp_lat = 2;
    run_scan(1'b0); // R11: count from the previous scan is cleared
    verify_results();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mixed();
    t_overflow();
    t_empty();
    t_mixed();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule